// File: doc/BRIEF.md
# Word Store Command Register Interface

This block gives a processor a small set of byte-wide registers that control a word-organised non-volatile store, modelled here as an internal array of 16-bit words. Software loads a 16-bit data buffer one byte at a time and forms a 16-bit address word from two bytes. It then writes a command byte. The address word carries both the target word and an operation code in its upper bits. The command byte selects one of three actions through strobe bits with a fixed priority. The block makes no model of serial wire timing.

A parameter picks one of two organisations: 64 words or 1024 words. This choice moves the operation-code and sub-code fields inside the address word. A zero operation code with the extended strobe runs one of four extended operations: lock writes, unlock writes, clear the whole store, or a write-all that does nothing. Reading the command register returns the last command byte with acknowledge bits merged in. Which acknowledge bits appear depends on the strobe that byte carried.

Top module: `eeprom_cmd_regs`

## Requirements
- R1: Register select codes are 0 data low byte, 1 data high byte, 2 address low byte, 3 address high byte and 4 command/status. Writes with select 5 to 7 are ignored and reads of them return 0x00. The address word is {address high, address low}. With WIDE_ORG=0 the opcode is bits 7:6, the sub-code is bits 5:4 and the word index is bits 5:0. Opcode and sub-code have no effect on a plain write or read.
- R2: With WIDE_ORG=1 the opcode is bits 11:10, the sub-code is bits 9:8 and the word index is bits 9:0.
- R3: An extended command acts only when the opcode is 00. It then uses the sub-code: 00 clears the write-enable latch, 11 sets it, 10 clears the store, and 01 changes neither the store nor the latch. An extended command with a nonzero opcode has no effect.
- R4: A command byte is decoded with priority: bit 6 (extended) first, then bit 5 (write), then bit 4 (read). A byte with none of these bits set causes no operation.
- R5: A write command stores the data buffer into the indexed word only while the write-enable latch is set. Otherwise the store is unchanged.
- R6: A read command loads the indexed word into the data buffer. Its low byte is then readable at select 0 and its high byte at select 1.
- R7: Clearing the store sets every word to 0x0000.
- R8: A status read (select 4) returns the last command byte c in one of three forms: c|0x02 if c bit 5 is set, else c|0x01 if c bit 4 is set, else c|0x03.
- R9: After reset the latch is clear and the buffer, address bytes, last command and all words are zero, so status reads 0x03.
- R10: A data or address byte write replaces only that byte. The address bytes read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 3 | Register select |
| wrStrobe | input | 1 | Register write, one cycle per byte |
| wrData | input | 8 | Byte to write |
| rdData | output | 8 | Combinational read of the selected register |

## Verification
The assertions assume that regSel is always a known value and that a command write lasts one cycle, so each command causes one operation. They also assume the data buffer is not written in the same cycle as a command. The single-register bus makes that impossible. The bench drives only through one-cycle register writes at the falling edge. It reads the combinational output mid-cycle, so every assumed condition holds for all stimulus.

// File: rtl/eeprom_cmd_pkg.sv
package eeprom_cmd_pkg;

  localparam logic [2:0] SEL_DATA_LO = 3'd0;
  localparam logic [2:0] SEL_DATA_HI = 3'd1;
  localparam logic [2:0] SEL_ADDR_LO = 3'd2;
  localparam logic [2:0] SEL_ADDR_HI = 3'd3;
  localparam logic [2:0] SEL_CMD     = 3'd4;

  localparam int BIT_EXT = 6;
  localparam int BIT_WR  = 5;
  localparam int BIT_RD  = 4;

  typedef enum logic [1:0] {
    SUB_LOCK  = 2'b00,
    SUB_FILL  = 2'b01,
    SUB_CLEAR = 2'b10,
    SUB_OPEN  = 2'b11
  } subCode_e;

  typedef struct packed {
    logic loadWord;
    logic storeWord;
    logic clearAll;
    logic setLatch;
    logic clearLatch;
  } eeCtrl_t;

  function automatic logic [7:0] statusFor(input logic [7:0] lastCmd);
    if (lastCmd[BIT_WR])      return lastCmd | 8'h02;
    else if (lastCmd[BIT_RD]) return lastCmd | 8'h01;
    else                      return lastCmd | 8'h03;
  endfunction

endpackage

// File: rtl/eeprom_cmd_ctrl.sv
module eeprom_cmd_ctrl
  import eeprom_cmd_pkg::*;
#(
  parameter bit WIDE_ORG = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdWrite,
  input  logic [7:0]  cmdByte,
  input  logic [15:0] addrWord,
  output eeCtrl_t     ctrl,
  output logic        wrEnLatch
);

  localparam int OP_LSB = WIDE_ORG ? 10 : 6;
  localparam int SUB_LSB = OP_LSB - 2;

  logic [1:0] opField;
  logic [1:0] subField;

  generate
    if (WIDE_ORG) begin : g_wide
      assign opField  = addrWord[11:10];
      assign subField = addrWord[9:8];
    end else begin : g_narrow
      assign opField  = addrWord[7:6];
      assign subField = addrWord[5:4];
    end
  endgenerate

  logic isExt, isWr, isRd;
  assign isExt = cmdByte[BIT_EXT];
  assign isWr  = !cmdByte[BIT_EXT] && cmdByte[BIT_WR];
  assign isRd  = !cmdByte[BIT_EXT] && !cmdByte[BIT_WR] && cmdByte[BIT_RD];

  always_comb begin
    ctrl = '0;
    if (cmdWrite) begin
      if (isExt) begin
        if (opField == 2'b00) begin
          case (subCode_e'(subField))
            SUB_LOCK:  ctrl.clearLatch = 1'b1;
            SUB_OPEN:  ctrl.setLatch   = 1'b1;
            SUB_CLEAR: ctrl.clearAll   = 1'b1;
            default:   ctrl            = '0;
          endcase
        end
      end else if (isWr) begin
        ctrl.storeWord = wrEnLatch;
      end else if (isRd) begin
        ctrl.loadWord = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               wrEnLatch <= 1'b0;
    else if (ctrl.setLatch)  wrEnLatch <= 1'b1;
    else if (ctrl.clearLatch) wrEnLatch <= 1'b0;
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ctrl)); // R4

  AST_LATCH_ONLY_EXT: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdWrite && cmdByte[BIT_EXT]) |=> $stable(wrEnLatch)); // R3

  AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !cmdWrite |-> (ctrl == '0)); // R4

endmodule

// File: rtl/eeprom_cmd_datapath.sv
module eeprom_cmd_datapath
  import eeprom_cmd_pkg::*;
#(
  parameter bit WIDE_ORG = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  regSel,
  input  logic        wrStrobe,
  input  logic [7:0]  wrData,
  input  eeCtrl_t     ctrl,
  output logic [7:0]  rdData,
  output logic [15:0] addrWord,
  output logic        cmdWrite,
  output logic [7:0]  cmdByte
);

  localparam int IDX_W = WIDE_ORG ? 10 : 6;
  localparam int WORDS = 1 << IDX_W;

  logic [15:0] dataBuf;
  logic [7:0]  addrLo, addrHi, lastCmd;
  logic [15:0] store [WORDS];
  logic [IDX_W-1:0] wordIdx;
  logic [15:0] curWord;
  logic anyNonZero;

  assign addrWord = {addrHi, addrLo};
  assign wordIdx  = addrWord[IDX_W-1:0];
  assign curWord  = store[wordIdx];
  assign cmdWrite = wrStrobe && (regSel == SEL_CMD);
  assign cmdByte  = wrData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrLo  <= '0;
      addrHi  <= '0;
      lastCmd <= '0;
    end else if (wrStrobe) begin
      case (regSel)
        SEL_ADDR_LO: addrLo  <= wrData;
        SEL_ADDR_HI: addrHi  <= wrData;
        SEL_CMD:     lastCmd <= wrData;
        default:     ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataBuf <= '0;
    end else if (ctrl.loadWord) begin
      dataBuf <= curWord;
    end else if (wrStrobe && regSel == SEL_DATA_LO) begin
      dataBuf[7:0] <= wrData;
    end else if (wrStrobe && regSel == SEL_DATA_HI) begin
      dataBuf[15:8] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.clearAll) begin
      for (int i = 0; i < WORDS; i++) store[i] <= '0;
    end else if (ctrl.storeWord) begin
      store[wordIdx] <= dataBuf;
    end
  end

  always_comb begin
    case (regSel)
      SEL_DATA_LO: rdData = dataBuf[7:0];
      SEL_DATA_HI: rdData = dataBuf[15:8];
      SEL_ADDR_LO: rdData = addrLo;
      SEL_ADDR_HI: rdData = addrHi;
      SEL_CMD:     rdData = statusFor(lastCmd);
      default:     rdData = 8'h00;
    endcase
  end

  always_comb begin
    anyNonZero = 1'b0;
    for (int i = 0; i < WORDS; i++) anyNonZero = anyNonZero | (|store[i]);
  end

  AST_STORE_TAKES_BUFFER: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.storeWord |=> (store[$past(wordIdx)] == $past(dataBuf))); // R5

  AST_LOAD_FILLS_BUFFER: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.loadWord |=> (dataBuf == $past(curWord))); // R6

  AST_ERASE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.clearAll |=> !anyNonZero); // R7

  AST_STATUS_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (regSel == SEL_CMD) |-> (rdData[1:0] != 2'b00)); // R8

  AST_BUF_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!wrStrobe && !ctrl.loadWord) |=> $stable(dataBuf)); // R10

endmodule

// File: rtl/eeprom_cmd_regs.sv
module eeprom_cmd_regs
  import eeprom_cmd_pkg::*;
#(
  parameter bit WIDE_ORG = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] regSel,
  input  logic       wrStrobe,
  input  logic [7:0] wrData,
  output logic [7:0] rdData
);

  eeCtrl_t     ctrl;
  logic [15:0] addrWord;
  logic        cmdWrite;
  logic [7:0]  cmdByte;
  logic        wrEnLatch;

  eeprom_cmd_datapath #(.WIDE_ORG(WIDE_ORG)) u_datapath (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrStrobe(wrStrobe),
    .wrData(wrData), .ctrl(ctrl), .rdData(rdData), .addrWord(addrWord),
    .cmdWrite(cmdWrite), .cmdByte(cmdByte)
  );

  eeprom_cmd_ctrl #(.WIDE_ORG(WIDE_ORG)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdWrite(cmdWrite), .cmdByte(cmdByte),
    .addrWord(addrWord), .ctrl(ctrl), .wrEnLatch(wrEnLatch)
  );

endmodule

// File: tb/eeprom_cmd_regs_bench.sv
module eeprom_cmd_regs_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] regSel = 3'd0;
  logic       wrN = 1'b0, wrW = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdN, rdW;

  int checks = 0;
  int errors = 0;
  logic [15:0] model [64];

  always #10 clk = ~clk;

  eeprom_cmd_regs #(.WIDE_ORG(1'b0)) u_eeprom_cmd_regs (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrStrobe(wrN),
    .wrData(wrData), .rdData(rdN));

  eeprom_cmd_regs #(.WIDE_ORG(1'b1)) u_eeprom_cmd_regs_wide (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrStrobe(wrW),
    .wrData(wrData), .rdData(rdW));

  function automatic logic [15:0] pat(input int a);
    return 16'((a * 16'h0123) ^ 16'hA55A);
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input bit wide, input logic [2:0] sel, input logic [7:0] val);
    @(negedge clk);
    regSel = sel; wrData = val;
    if (wide) wrW = 1'b1; else wrN = 1'b1;
    @(negedge clk);
    wrN = 1'b0; wrW = 1'b0;
  endtask

  task automatic rd(input bit wide, input logic [2:0] sel, output logic [7:0] val);
    regSel = sel;
    #1;
    val = wide ? rdW : rdN;
  endtask

  task automatic rdWord(input bit wide, output logic [15:0] w);
    logic [7:0] lo, hi;
    rd(wide, 3'd0, lo);
    rd(wide, 3'd1, hi);
    w = {hi, lo};
  endtask

  task automatic cmdAt(input bit wide, input logic [15:0] aw, input logic [7:0] c);
    wr(wide, 3'd2, aw[7:0]);
    wr(wide, 3'd3, aw[15:8]);
    wr(wide, 3'd4, c);
  endtask

  task automatic setBuf(input bit wide, input logic [15:0] d);
    wr(wide, 3'd0, d[7:0]);
    wr(wide, 3'd1, d[15:8]);
  endtask

  task automatic readAt(input bit wide, input logic [15:0] aw, output logic [15:0] w);
    cmdAt(wide, aw, 8'h10);
    rdWord(wide, w);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] b;
    logic [15:0] w;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R9 reset state, R1 unused selects read zero
    for (int s = 0; s < 4; s++) begin
      rd(0, 3'(s), b); check("R9 reset register", {8'h00, b}, 16'h0000);
    end
    rd(0, 3'd4, b); check("R9 reset status", {8'h00, b}, 16'h0003);
    rd(0, 3'd6, b); check("R1 unused select", {8'h00, b}, 16'h0000);
    readAt(0, 16'h0007, w); check("R9 store zero", w, 16'h0000);
    rd(0, 3'd4, b); check("R8 read status", {8'h00, b}, 16'h0011);

    // R5 write without latch ignored
    setBuf(0, 16'hBEEF);
    cmdAt(0, 16'h0009, 8'h21);
    rd(0, 3'd4, b); check("R8 write status", {8'h00, b}, 16'h0023);
    readAt(0, 16'h0009, w); check("R5 locked write", w, 16'h0000);

    // R10 byte replacement and address readback
    wr(0, 3'd0, 8'hAB); wr(0, 3'd1, 8'hCD); wr(0, 3'd0, 8'h12);
    rdWord(0, w); check("R10 byte replace", w, 16'hCD12);
    wr(0, 3'd2, 8'h5E); wr(0, 3'd3, 8'hC3);
    rd(0, 3'd2, b); check("R10 addr low", {8'h00, b}, 16'h005E);
    rd(0, 3'd3, b); check("R10 addr high", {8'h00, b}, 16'h00C3);
    wr(0, 3'd5, 8'hFF);
    rdWord(0, w); check("R1 ignored select write", w, 16'hCD12);

    // R3 unlock; R1 sweep with opcode bits scrambled and high byte set
    cmdAt(0, 16'h0030, 8'h40);
    rd(0, 3'd4, b); check("R8 ext status", {8'h00, b}, 16'h0043);
    for (int a = 0; a < 64; a++) begin
      setBuf(0, pat(a));
      cmdAt(0, {8'h5A, 2'(a), 6'(a)}, 8'h20);
      model[a] = pat(a);
    end
    for (int a = 0; a < 64; a++) begin
      readAt(0, {8'hF0, 2'(~a), 6'(a)}, w); check("R6 sweep readback", w, model[a]);
    end

    // R4 write beats read
    setBuf(0, 16'h1357);
    cmdAt(0, 16'h0005, 8'h30);
    rdWord(0, w); check("R4 write over read buffer", w, 16'h1357);
    model[5] = 16'h1357;
    readAt(0, 16'h0005, w); check("R4 write over read stored", w, 16'h1357);
    // R4 no strobe bits
    setBuf(0, 16'hFFFF);
    cmdAt(0, 16'h0006, 8'h0F);
    rd(0, 3'd4, b); check("R8 idle status", {8'h00, b}, 16'h000F);
    readAt(0, 16'h0006, w); check("R4 no-op command", w, model[6]);

    // R3 write-all does nothing; latch stays set
    cmdAt(0, 16'h0010, 8'h40);
    readAt(0, 16'h0003, w); check("R3 write-all store", w, model[3]);
    setBuf(0, 16'h7777); cmdAt(0, 16'h0003, 8'h20); model[3] = 16'h7777;
    readAt(0, 16'h0003, w); check("R3 write-all latch", w, 16'h7777);
    // R3 nonzero opcode extended ignored
    cmdAt(0, 16'h00A0, 8'h40);
    readAt(0, 16'h0000, w); check("R3 opcode gate", w, model[0]);
    // R3 lock
    cmdAt(0, 16'h0000, 8'h40);
    setBuf(0, 16'h0F0F); cmdAt(0, 16'h0001, 8'h20);
    readAt(0, 16'h0001, w); check("R3 lock blocks write", w, model[1]);

    // R7 clear with R4 extended priority
    cmdAt(0, 16'h0020, 8'h70);
    rd(0, 3'd4, b); check("R8 ext+write status", {8'h00, b}, 16'h0072);
    for (int a = 0; a < 64; a++) begin
      readAt(0, 16'(a), w); check("R7 cleared", w, 16'h0000);
    end

    // R2 wide organisation
    cmdAt(1, 16'h0300, 8'h40);
    setBuf(1, 16'h6C6C); cmdAt(1, 16'h03FF, 8'h20);
    setBuf(1, 16'h1234); cmdAt(1, 16'h0155, 8'h20);
    readAt(1, 16'h03FF, w); check("R2 wide top word", w, 16'h6C6C);
    readAt(1, 16'h0155, w); check("R2 wide mid word", w, 16'h1234);
    readAt(1, 16'h00FF, w); check("R2 wide upper index bits", w, 16'h0000);
    cmdAt(1, 16'h0030, 8'h40);
    setBuf(1, 16'h9999); cmdAt(1, 16'h03FF, 8'h20);
    readAt(1, 16'h03FF, w); check("R2 wide lock", w, 16'h6C6C);
    cmdAt(1, 16'h0200, 8'h40);
    readAt(1, 16'h0155, w); check("R2 wide clear", w, 16'h0000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule